// File: doc/BRIEF.md
# Rectangle Fill Address Generator

This block drives the fill-with-constant operation of a two-dimensional DMA engine. Software, or an upstream sequencer, gives it a destination start address, a line offset, a pixel count per line, a line count, a fixed color word and a 3-bit output color mode. When `start_i` is pulsed, the block walks the rectangle row by row. For every pixel it issues one byte-addressed write request, which carries the color packed in the selected pixel size.

Each write request is presented on a valid/ready port. The pixel occupies the low bytes of the 32-bit data word, and the byte enables mark the bytes that belong to the pixel. The walk advances only when a request is accepted, so a slow memory side stalls the block without losing pixels. Two per-operation controls modify the stored color: one exchanges the red and blue fields, the other inverts the alpha field. At the end of each row the address jumps over the line offset, which is counted in pixels, and the next row starts there.

Top module: `rfill_gen`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `wr_valid_o` are all low.
- R2: A `start_i` pulse while idle captures every configuration input at that clock edge, and later changes to those inputs have no effect. On a non-empty rectangle, `busy_o` and `wr_valid_o` are high in the next cycle, and the first request targets the start address.
- R3: The mode code selects the pixel size and the byte enables: 000 gives 4 bytes with enables 1111, 001 gives 3 bytes with enables 0111, and 010, 011 and 100 give 2 bytes with enables 0011. Codes 101 to 111 behave as 000.
- R4: Within a row, each accepted request advances the address by the pixel size. After the last pixel of a row, the address advances by the pixel size times (1 + line offset).
- R5: With neither control set, the data word carries the color's low 4, 3 or 2 bytes unchanged, and all data bytes above the pixel are zero.
- R6: The red/blue swap exchanges the following fields, and leaves every other bit unchanged:
  - mode 000: bits 23:16 with bits 7:0
  - mode 001: bits 23:16 with bits 7:0
  - mode 010: bits 15:11 with bits 4:0
  - mode 011: bits 14:10 with bits 4:0
  - mode 100: bits 11:8 with bits 3:0
- R7: The alpha invert complements bits 31:24 in mode 000, bit 15 in mode 011 and bits 15:12 in mode 100. It has no effect in modes 001 and 010.
- R8: While `wr_valid_o` is high and `wr_ready_i` is low, the request stays valid and its address, data and byte enables hold.
- R9: Exactly pixels × lines requests are accepted, in row-major order. `done_o` is high for the one cycle after the last acceptance, and `busy_o` is low from that cycle on.
- R10: A zero pixel count or a zero line count makes `done_o` pulse in the cycle after the start, with no request issued and `busy_o` staying low.
- R11: A `start_i` pulse while busy is ignored, and the ongoing walk continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a fill; captured only while idle |
| cfg_addr_i | input | AW | Byte address of the first pixel |
| cfg_offset_i | input | OW | Pixels skipped between the end of one row and the start of the next |
| cfg_pixels_i | input | PW | Pixels per row |
| cfg_lines_i | input | LW | Number of rows |
| cfg_color_i | input | 32 | Fixed color, already in output packing |
| cfg_mode_i | input | 3 | Output color mode code |
| cfg_rbswap_i | input | 1 | Exchange red and blue fields |
| cfg_ainv_i | input | 1 | Invert the alpha field |
| busy_o | output | 1 | Fill in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_valid_o | output | 1 | Write request present |
| wr_ready_i | input | 1 | Write request accepted this cycle |
| wr_addr_o | output | AW | Byte address of the pixel |
| wr_data_o | output | 32 | Pixel data, low-byte aligned |
| wr_be_o | output | 4 | Byte enables of the pixel |

## Verification
The assertions check, on every cycle, the behaviours that hold regardless of configuration. A stalled request must keep its address, data and enables. The byte-enable pattern must be one of the three legal shapes, and the data bytes above a two-byte pixel must be zero. `done_o` must never coincide with activity, each fall of `busy_o` must come with `done_o`, and a start during a walk must leave the address alone. Only the bench's scenarios can show that the address sequence follows the strided row walk, that the packed color and the swap and invert effects are correct for each mode, and that the total request count matches the rectangle. They also show that empty rectangles finish at once and that configuration changed after the start has no effect.

// File: rtl/rfill_pkg.sv
// Shared constants for the rectangle fill generator.
// Assumes: color mode codes are 3 bits; codes 5..7 fall back to 32-bit pixels.
package rfill_pkg;
    localparam logic [2:0] CM_ARGB32 = 3'd0;
    localparam logic [2:0] CM_RGB24  = 3'd1;
    localparam logic [2:0] CM_RGB16  = 3'd2;
    localparam logic [2:0] CM_A1RGB5 = 3'd3;
    localparam logic [2:0] CM_ARGB4  = 3'd4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_e;

    typedef struct packed {
        logic [31:0] data;
        logic [3:0]  be;
        logic [2:0]  bytes;
    } pixel_t;
endpackage

// File: rtl/rfill_fmt.sv
// Pixel formatter: turns the fixed color into the stored pixel for the mode.
// Assumes: the color is already packed in the output format in its low bytes;
// only field exchange and alpha inversion are applied here.
module rfill_fmt
    import rfill_pkg::*;
(
    input  logic [2:0]  mode_i,
    input  logic [31:0] color_i,
    input  logic        rbswap_i,
    input  logic        ainv_i,
    output pixel_t      pix_o
);
    // Select packing, apply swap and alpha invert per mode.
    always_comb begin
        pix_o = '0;
        unique case (mode_i)
            CM_RGB24: begin
                pix_o.bytes = 3'd3;
                pix_o.be    = 4'b0111;
                pix_o.data  = rbswap_i ? {8'h00, color_i[7:0], color_i[15:8], color_i[23:16]}
                                       : {8'h00, color_i[23:0]};
            end
            CM_RGB16: begin
                pix_o.bytes = 3'd2;
                pix_o.be    = 4'b0011;
                pix_o.data  = rbswap_i ? {16'h0, color_i[4:0], color_i[10:5], color_i[15:11]}
                                       : {16'h0, color_i[15:0]};
            end
            CM_A1RGB5: begin
                pix_o.bytes = 3'd2;
                pix_o.be    = 4'b0011;
                pix_o.data  = rbswap_i ? {16'h0, color_i[15], color_i[4:0], color_i[9:5], color_i[14:10]}
                                       : {16'h0, color_i[15:0]};
                if (ainv_i) pix_o.data[15] = ~pix_o.data[15];
            end
            CM_ARGB4: begin
                pix_o.bytes = 3'd2;
                pix_o.be    = 4'b0011;
                pix_o.data  = rbswap_i ? {16'h0, color_i[15:12], color_i[3:0], color_i[7:4], color_i[11:8]}
                                       : {16'h0, color_i[15:0]};
                if (ainv_i) pix_o.data[15:12] = ~pix_o.data[15:12];
            end
            default: begin
                pix_o.bytes = 3'd4;
                pix_o.be    = 4'b1111;
                pix_o.data  = rbswap_i ? {color_i[31:24], color_i[7:0], color_i[15:8], color_i[23:16]}
                                       : color_i;
                if (ainv_i) pix_o.data[31:24] = ~pix_o.data[31:24];
            end
        endcase
    end
endmodule

// File: rtl/rfill_cnt.sv
// Row/column counter: tracks the pixel position inside the rectangle.
// Assumes: pixels_i and lines_i are non-zero whenever step_i is asserted.
module rfill_cnt #(
    parameter int PW = 16,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [PW-1:0] pixels_i,
    input  logic [LW-1:0] lines_i,
    output logic          row_end_o,
    output logic          last_o
);
    logic [PW-1:0] col_q;
    logic [LW-1:0] row_q;

    assign row_end_o = (col_q == pixels_i - PW'(1));
    assign last_o    = row_end_o && (row_q == lines_i - LW'(1));

    // Clear on load, advance column and wrap into the next row on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            col_q <= '0;
            row_q <= '0;
        end else if (step_i) begin
            if (row_end_o) begin
                col_q <= '0;
                row_q <= row_q + LW'(1);
            end else begin
                col_q <= col_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/rfill_addr.sv
// Address accumulator: byte address of the current pixel, strided per row.
// Assumes: bytes_i is stable during a walk; offset counts pixels.
module rfill_addr #(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          step_i,
    input  logic          row_end_i,
    input  logic [2:0]    bytes_i,
    input  logic [OW-1:0] offset_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] skip;

    // Gap added after a row: offset pixels times pixel size.
    always_comb skip = AW'(offset_i) * AW'(bytes_i);

    // Load the start address, then step by one pixel plus the row gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= start_addr_i;
        end else if (step_i) begin
            addr_q <= addr_q + AW'(bytes_i) + (row_end_i ? skip : '0);
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/rfill_gen.sv
// Rectangle fill generator top: captures the configuration on start, walks
// the rectangle and emits one write request per pixel.
// Assumes: the downstream accepts a request in any cycle where both valid
// and ready are high; configuration inputs are sampled only at start.
module rfill_gen
    import rfill_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 16,
    parameter int PW = 16,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] cfg_addr_i,
    input  logic [OW-1:0] cfg_offset_i,
    input  logic [PW-1:0] cfg_pixels_i,
    input  logic [LW-1:0] cfg_lines_i,
    input  logic [31:0]   cfg_color_i,
    input  logic [2:0]    cfg_mode_i,
    input  logic          cfg_rbswap_i,
    input  logic          cfg_ainv_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          wr_valid_o,
    input  logic          wr_ready_i,
    output logic [AW-1:0] wr_addr_o,
    output logic [31:0]   wr_data_o,
    output logic [3:0]    wr_be_o
);
    fill_state_e   state_q;
    logic          done_q;
    logic [OW-1:0] off_q;
    logic [PW-1:0] pix_q;
    logic [LW-1:0] lines_q;
    logic [31:0]   color_q;
    logic [2:0]    mode_q;
    logic          swap_q;
    logic          ainv_q;

    logic   launch;
    logic   empty;
    logic   accept;
    logic   row_end;
    logic   last;
    pixel_t pix;

    assign launch = start_i && (state_q == ST_IDLE);
    assign empty  = (cfg_pixels_i == '0) || (cfg_lines_i == '0);
    assign accept = (state_q == ST_RUN) && wr_ready_i;

    // Capture the configuration when a start is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q   <= '0;
            pix_q   <= '0;
            lines_q <= '0;
            color_q <= '0;
            mode_q  <= CM_ARGB32;
            swap_q  <= 1'b0;
            ainv_q  <= 1'b0;
        end else if (launch) begin
            off_q   <= cfg_offset_i;
            pix_q   <= cfg_pixels_i;
            lines_q <= cfg_lines_i;
            color_q <= cfg_color_i;
            mode_q  <= cfg_mode_i;
            swap_q  <= cfg_rbswap_i;
            ainv_q  <= cfg_ainv_i;
        end
    end

    // Control: idle/run sequencing and the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                if (empty) done_q  <= 1'b1;
                else       state_q <= ST_RUN;
            end else if (accept && last) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
            end
        end
    end

    rfill_fmt u_fmt (
        .mode_i   (mode_q),
        .color_i  (color_q),
        .rbswap_i (swap_q),
        .ainv_i   (ainv_q),
        .pix_o    (pix)
    );

    rfill_cnt #(.PW(PW), .LW(LW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (launch),
        .step_i    (accept),
        .pixels_i  (pix_q),
        .lines_i   (lines_q),
        .row_end_o (row_end),
        .last_o    (last)
    );

    rfill_addr #(.AW(AW), .OW(OW)) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (launch),
        .start_addr_i (cfg_addr_i),
        .step_i       (accept),
        .row_end_i    (row_end),
        .bytes_i      (pix.bytes),
        .offset_i     (off_q),
        .addr_o       (wr_addr_o)
    );

    assign busy_o     = (state_q == ST_RUN);
    assign wr_valid_o = (state_q == ST_RUN);
    assign done_o     = done_q;
    assign wr_data_o  = pix.data;
    assign wr_be_o    = pix.be;
endmodule

// File: rtl/rfill_gen_chk.sv
// Checker for rfill_gen: protocol and completion properties, bound to the top.
// Assumes: synchronous active-low reset shared with the design.
module rfill_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          wr_valid_o,
    input logic          wr_ready_i,
    input logic [AW-1:0] wr_addr_o,
    input logic [31:0]   wr_data_o,
    input logic [3:0]    wr_be_o
);
    // R8: a stalled request holds steady.
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o)
                                      && $stable(wr_data_o) && $stable(wr_be_o));

    // R3: byte enables take one of the three legal shapes.
    a_r3_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (wr_be_o == 4'b1111 || wr_be_o == 4'b0111 || wr_be_o == 4'b0011));

    // R5: bytes above a two-byte pixel are zero.
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && wr_be_o == 4'b0011 |-> wr_data_o[31:16] == 16'h0);

    // R9: completion never overlaps activity.
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !wr_valid_o);

    // R9: every end of a walk is signalled.
    a_r9_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R11: a start during a stalled walk moves nothing.
    a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !wr_ready_i |=> $stable(wr_addr_o) && busy_o);
endmodule

bind rfill_gen rfill_gen_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_be_o    (wr_be_o)
);

// File: tb/rfill_gen_bench.sv
// Sweep bench for rfill_gen: all modes, small rectangles, both offsets,
// swap/invert combinations, with and without backpressure.
module rfill_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int OW = 16;
    localparam int PW = 16;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] cfg_addr_i = '0;
    logic [OW-1:0] cfg_offset_i = '0;
    logic [PW-1:0] cfg_pixels_i = '0;
    logic [LW-1:0] cfg_lines_i = '0;
    logic [31:0]   cfg_color_i = '0;
    logic [2:0]    cfg_mode_i = '0;
    logic          cfg_rbswap_i = 1'b0;
    logic          cfg_ainv_i = 1'b0;
    logic          busy_o, done_o, wr_valid_o;
    logic          wr_ready_i = 1'b0;
    logic [AW-1:0] wr_addr_o;
    logic [31:0]   wr_data_o;
    logic [3:0]    wr_be_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    rfill_gen #(.AW(AW), .OW(OW), .PW(PW), .LW(LW)) u_rfill_gen (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: R9 run did not finish, actual cycles %0d expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    function automatic int bytes_of(input logic [2:0] m);
        if (m == 3'd1) return 3;
        if (m == 3'd2 || m == 3'd3 || m == 3'd4) return 2;
        return 4;
    endfunction

    function automatic logic [3:0] be_of(input logic [2:0] m);
        case (bytes_of(m))
            3: return 4'b0111;
            2: return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // Expected pixel, built field by field from the requirements.
    function automatic logic [31:0] pix_of(input logic [2:0] m, input logic [31:0] c,
                                           input logic sw, input logic ai);
        logic [7:0] a8, r8, g8, b8;
        logic [4:0] r5, b5;
        logic [3:0] a4, r4, g4, b4;
        logic [5:0] g6;
        logic [4:0] g5;
        logic       a1;
        case (m)
            3'd1: begin
                r8 = c[23:16]; g8 = c[15:8]; b8 = c[7:0];
                return sw ? {8'h0, b8, g8, r8} : {8'h0, r8, g8, b8};
            end
            3'd2: begin
                r5 = c[15:11]; g6 = c[10:5]; b5 = c[4:0];
                return sw ? {16'h0, b5, g6, r5} : {16'h0, r5, g6, b5};
            end
            3'd3: begin
                a1 = c[15] ^ ai; r5 = c[14:10]; g5 = c[9:5]; b5 = c[4:0];
                return sw ? {16'h0, a1, b5, g5, r5} : {16'h0, a1, r5, g5, b5};
            end
            3'd4: begin
                a4 = c[15:12] ^ {4{ai}}; r4 = c[11:8]; g4 = c[7:4]; b4 = c[3:0];
                return sw ? {16'h0, a4, b4, g4, r4} : {16'h0, a4, r4, g4, b4};
            end
            default: begin
                a8 = c[31:24] ^ {8{ai}}; r8 = c[23:16]; g8 = c[15:8]; b8 = c[7:0];
                return sw ? {a8, b8, g8, r8} : {a8, r8, g8, b8};
            end
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input logic [2:0] m, input int np, input int nl, input int off,
                           input logic sw, input logic ai, input logic [31:0] base,
                           input logic [31:0] col, input bit stall);
        int n = 0;
        int bpp = bytes_of(m);
        int last_acc = -1;
        int done_at = -1;
        bit ready;
        logic [31:0] ea;
        @(negedge clk);
        cfg_mode_i = m; cfg_pixels_i = PW'(np); cfg_lines_i = LW'(nl);
        cfg_offset_i = OW'(off); cfg_rbswap_i = sw; cfg_ainv_i = ai;
        cfg_addr_i = base; cfg_color_i = col; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R2: later configuration changes must not matter.
        cfg_addr_i = 32'hFFFF_0000; cfg_color_i = ~col; cfg_mode_i = 3'd2;
        cfg_pixels_i = PW'(7); cfg_offset_i = OW'(9); cfg_rbswap_i = ~sw; cfg_ainv_i = ~ai;
        if (np != 0 && nl != 0) begin
            check(busy_o && wr_valid_o, "R2", "busy after start", {30'h0, busy_o, wr_valid_o}, 32'h3);
            check(wr_addr_o == base, "R2", "first address", wr_addr_o, base);
        end
        for (int cyc = 0; cyc < 200 && done_at < 0; cyc++) begin
            ready = stall ? ((cyc % 3) != 1) : 1'b1;
            wr_ready_i = ready;
            if (done_o) done_at = cyc;
            // R11: pulse start while walking.
            start_i = busy_o && ((cyc % 5) == 2);
            if (wr_valid_o && ready) begin
                ea = base + 32'((n / np) * (np + off) * bpp + (n % np) * bpp);
                check(wr_addr_o == ea, "R4", "address", wr_addr_o, ea);
                check(wr_be_o == be_of(m), "R3", "byte enables", {28'h0, wr_be_o}, {28'h0, be_of(m)});
                check(wr_data_o == pix_of(m, col, sw, ai), "R5 R6 R7", "pixel data",
                      wr_data_o, pix_of(m, col, sw, ai));
                n++;
                last_acc = cyc;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        wr_ready_i = 1'b0;
        check(n == np * nl, "R9", "request count", 32'(n), 32'(np * nl));
        if (np == 0 || nl == 0)
            check(done_at == 0, "R10", "empty done cycle", 32'(done_at), 32'd0);
        else
            check(done_at == last_acc + 1, "R9", "done cycle", 32'(done_at), 32'(last_acc + 1));
        check(!busy_o && !wr_valid_o, "R9", "idle after done", {30'h0, busy_o, wr_valid_o}, 32'h0);
    endtask

    initial begin
        int idx = 0;
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !wr_valid_o, "R1", "reset state",
              {29'h0, busy_o, done_o, wr_valid_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !wr_valid_o, "R1", "state after reset release",
              {29'h0, busy_o, done_o, wr_valid_o}, 32'h0);
        for (int m = 0; m < 6; m++)
            for (int np = 0; np < 4; np++)
                for (int nl = 0; nl < 4; nl++)
                    for (int o = 0; o < 2; o++)
                        for (int k = 0; k < 4; k++)
                            for (int s = 0; s < 2; s++) begin
                                run_one(3'(m), np, nl, o * 3, k[0], k[1],
                                        32'h0000_1000 + 32'(idx * 13),
                                        32'hA5C3_1E7B ^ (32'(idx) * 32'h0101_0107), s[0]);
                                idx++;
                            end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule